// File: doc/BRIEF.md
# Unaligned Load/Store Splitter

This block connects a processor load/store port that works with byte addresses to a synchronous RAM that stores 32-bit words. The RAM sees only the word address. The two low address bits select byte lanes, and they never reach the RAM. A request can be a byte, a half-word or a word. When all its bytes lie inside one aligned word, the block makes one memory cycle. For a read it extracts the bytes. For a write it raises only the byte-lane enables the request covers.

A request whose bytes cross a word boundary is not trapped by default. The block splits it into two back-to-back memory cycles: first the word at the aligned base, then the following word. For a read, it shifts the two words against each other by the byte offset and merges them into one right-justified result. For a write, it splits the store into two masked word writes. The processor sees a busy flag while the block works and one done pulse per accepted request.

A trap-mode input makes the block reject boundary-crossing requests instead. Such a request then makes no memory cycle and returns a fault flag together with its done pulse.

Top module: `unaligned_lsu`

## Requirements
- R1: While reset is asserted, and after it, with no request yet, reqBusy, reqDone, misalignFault, memEn and memWe are all zero.
- R2: A read that fits inside one aligned word makes exactly one memory cycle. Its reqDone pulse and data appear two clock edges after the edge that accepts it. The data is right-justified and zero-extended. Size encoding: reqSize 0 is a byte, 1 is a half-word, 2 or 3 is a word.
- R3: A boundary-crossing read makes exactly two memory cycles: word address base, then base+1. It returns the merged bytes three edges after acceptance. For example, with bytes 01..08 at addresses 0..7, a word read at address 1 returns 0x02030405.
- R4: Byte order within a word is big-endian. Byte offset 0 occupies bits 31:24 of a RAM word and is enabled by memWe[3]. Offset k is enabled by memWe[3-k].
- R5: A write that fits inside one word makes one memory cycle. memWe covers exactly the addressed lanes, and the store data (right-justified in reqWdata) is placed in those lanes.
- R6: A boundary-crossing write makes two memory cycles. The first, at the base word, enables only the lanes at the offset and above. The second, at base+1, enables only the remaining low-offset lanes. Together they store the value byte-exact.
- R7: Each accepted request produces exactly one single-cycle reqDone pulse. A request is accepted only when reqValid is high and reqBusy is low. A reqValid raised while busy is ignored and leaves memory unchanged.
- R8: With trapMode high, a boundary-crossing request makes no memory cycle and raises misalignFault together with reqDone one edge after acceptance. A non-crossing request in trap mode behaves as in R2 or R5.
- R9: Byte requests never cross. A half-word crosses only at offset 3. A word crosses at any non-zero offset.
- R10: A crossing access in the last word of the address space wraps its second cycle to word address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapMode | input | 1 | 1: fault on boundary-crossing requests instead of splitting them |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 half-word, 2/3 word |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Store data, right-justified |
| reqBusy | output | 1 | Block is working on an accepted request |
| reqDone | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Load result, valid with reqDone |
| misalignFault | output | 1 | Trap-mode fault, valid with reqDone |
| memEn | output | 1 | RAM access strobe |
| memWe | output | 4 | Per-lane write enables |
| memAddr | output | ADDR_W-2 | RAM word address |
| memWdata | output | 32 | RAM write data |
| memRdata | input | 32 | RAM read data, one cycle after memEn |

## Verification
Counted from the edge that accepts a request, reqDone and the load data are due after two edges for a single-word access and after three for a split access. A trapped request completes after one edge. The RAM's own read latency of one cycle is included in those counts. Each directed task drives its request on a falling edge and then counts falling edges until reqDone. It compares that count with 1, 2 or 3 and compares the result sampled on that falling edge. A falling-edge monitor records the address and write enables of every memory cycle. The lane masks, the base+1 ordering and the wrap can then be checked exactly, and stores are checked again by reading the words back through the block.

// File: rtl/ualsu_pkg.sv
package ualsu_pkg;

  localparam int WordBytes = 4;
  localparam int DataW     = 8 * WordBytes;

  typedef struct packed {
    logic latchReq;
    logic issueFirst;
    logic issueSecond;
    logic captureFirst;
    logic finish;
  } ctrlStrobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ualsu_ctrl.sv
module ualsu_ctrl
  import ualsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        trapMode,
  input  logic        reqCross,
  input  logic        heldCross,
  output ctrlStrobe_t strobe,
  output logic        reqBusy,
  output logic        reqDone,
  output logic        misalignFault,
  output logic        memEn
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_SECOND, ST_FINISH, ST_FAULT
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        strobe.latchReq = reqValid;
        if (reqValid) stateNext = (trapMode && reqCross) ? ST_FAULT : ST_FIRST;
      end
      ST_FIRST: begin
        strobe.issueFirst = 1'b1;
        stateNext = heldCross ? ST_SECOND : ST_FINISH;
      end
      ST_SECOND: begin
        strobe.issueSecond  = 1'b1;
        strobe.captureFirst = 1'b1;
        stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign reqBusy       = (state != ST_IDLE);
  assign reqDone       = (state == ST_FINISH) || (state == ST_FAULT);
  assign misalignFault = (state == ST_FAULT);
  assign memEn         = (state == ST_FIRST) || (state == ST_SECOND);

endmodule

// File: rtl/ualsu_datapath.sv
module ualsu_datapath
  import ualsu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DataW-1:0]     reqWdata,
  input  logic [DataW-1:0]     memRdata,
  output logic                 reqCross,
  output logic                 heldCross,
  output logic [WordBytes-1:0] memWe,
  output logic [ADDR_W-3:0]    memAddr,
  output logic [DataW-1:0]     memWdata,
  output logic [DataW-1:0]     rspData
);

  localparam int WordAddrW = ADDR_W - 2;

  logic                 hWrite;
  logic [1:0]           hSize;
  logic [1:0]           hOff;
  logic [WordAddrW-1:0] hBase;
  logic [DataW-1:0]     hData;
  logic [DataW-1:0]     word0Reg;

  // Crossing test on the incoming request: offset plus length past one word
  logic [2:0] inBytes;
  always_comb begin
    inBytes  = sizeBytes(reqSize);
    reqCross = ({1'b0, reqAddr[1:0]} + inBytes) > 3'd4;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hWrite    <= 1'b0;
      hSize     <= 2'd0;
      hOff      <= 2'd0;
      hBase     <= '0;
      hData     <= '0;
      heldCross <= 1'b0;
      word0Reg  <= '0;
    end else begin
      if (strobe.latchReq) begin
        hWrite    <= reqWrite;
        hSize     <= reqSize;
        hOff      <= reqAddr[1:0];
        hBase     <= reqAddr[ADDR_W-1:2];
        hData     <= reqWdata;
        heldCross <= reqCross;
      end
      if (strobe.captureFirst) word0Reg <= memRdata;
    end
  end

  // Shift amounts derived from the held size and offset
  logic [2:0] nBytes;
  logic [2:0] padBytes;
  logic [5:0] padBits;
  logic [5:0] offBits;
  always_comb begin
    nBytes   = sizeBytes(hSize);
    padBytes = 3'd4 - nBytes;
    padBits  = {padBytes, 3'b000};
    offBits  = {1'b0, hOff, 3'b000};
  end

  // Store side: place the value across a two-word window, then split it
  logic [DataW-1:0]       leftData;
  logic [2*DataW-1:0]     wrSpan;
  logic [WordBytes-1:0]   leftMask;
  logic [2*WordBytes-1:0] laneSpan;
  always_comb begin
    leftData = hData << padBits;
    wrSpan   = {leftData, {DataW{1'b0}}} >> offBits;
    leftMask = 4'b1111 << padBytes;
    laneSpan = {leftMask, 4'b0000} >> hOff;
  end

  logic [WordBytes-1:0] firstMask, secondMask;
  assign firstMask  = laneSpan[2*WordBytes-1:WordBytes];
  assign secondMask = laneSpan[WordBytes-1:0];

  genvar lane;
  generate
    for (lane = 0; lane < WordBytes; lane++) begin : g_lane
      always_comb begin
        memWe[lane] = hWrite && ((strobe.issueFirst  && firstMask[lane]) ||
                                 (strobe.issueSecond && secondMask[lane]));
        memWdata[8*lane +: 8] = strobe.issueSecond ? wrSpan[8*lane +: 8]
                                                   : wrSpan[DataW + 8*lane +: 8];
      end
    end
  endgenerate

  assign memAddr = strobe.issueSecond ? hBase + 1'b1 : hBase;

  // Load side: join the words, shift out the leading bytes, right-justify
  logic [2*DataW-1:0] rdSpan;
  logic [2*DataW-1:0] rdShift;
  logic [DataW-1:0]   rdValue;
  always_comb begin
    rdSpan  = heldCross ? {word0Reg, memRdata} : {memRdata, {DataW{1'b0}}};
    rdShift = rdSpan << offBits;
    rdValue = rdShift[2*DataW-1:DataW] >> padBits;
    rspData = (strobe.finish && !hWrite) ? rdValue : '0;
  end

endmodule

// File: rtl/unaligned_lsu.sv
module unaligned_lsu
  import ualsu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqBusy,
  output logic              reqDone,
  output logic [31:0]       rspData,
  output logic              misalignFault,
  output logic              memEn,
  output logic [3:0]        memWe,
  output logic [ADDR_W-3:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);

  ctrlStrobe_t strobe;
  logic        reqCross;
  logic        heldCross;

  ualsu_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .trapMode      (trapMode),
    .reqCross      (reqCross),
    .heldCross     (heldCross),
    .strobe        (strobe),
    .reqBusy       (reqBusy),
    .reqDone       (reqDone),
    .misalignFault (misalignFault),
    .memEn         (memEn)
  );

  ualsu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memRdata  (memRdata),
    .reqCross  (reqCross),
    .heldCross (heldCross),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rspData   (rspData)
  );

endmodule

// File: rtl/unaligned_lsu_checker.sv
module unaligned_lsu_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqBusy,
  input logic              reqDone,
  input logic              misalignFault,
  input logic              memEn,
  input logic [3:0]        memWe,
  input logic [ADDR_W-3:0] memAddr
);

  // R7: acceptance makes the block busy on the next cycle
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqBusy) |=> reqBusy);

  // R7: done is a single-cycle pulse and releases the port
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> (!reqDone && !reqBusy));

  // R8: a fault comes with done and no RAM access
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> (reqDone && !memEn && memWe == 4'b0000));

  // R3 / R10: a second back-to-back RAM cycle targets the next word (modulo)
  p_second_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> (memAddr == $past(memAddr) + 1'b1));

  // R6: the two halves of a split store never enable the same lane
  p_split_lanes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> ((memWe & $past(memWe)) == 4'b0000));

  // R1: write enables only with a RAM access
  p_we_needs_en_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != 4'b0000) |-> memEn);

endmodule

bind unaligned_lsu unaligned_lsu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqBusy       (reqBusy),
  .reqDone       (reqDone),
  .misalignFault (misalignFault),
  .memEn         (memEn),
  .memWe         (memWe),
  .memAddr       (memAddr)
);

// File: tb/unaligned_lsu_test.sv
module unaligned_lsu_test;

  localparam int AW     = 12;
  localparam int NBYTES = 1 << AW;
  localparam int NWORDS = NBYTES / 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trapMode = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqSize = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          reqBusy, reqDone, misalignFault, memEn;
  logic [31:0]   rspData, memWdata;
  logic [31:0]   memRdata = '0;
  logic [3:0]    memWe;
  logic [AW-3:0] memAddr;

  always #2 clk = ~clk;

  unaligned_lsu #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .trapMode(trapMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBusy(reqBusy), .reqDone(reqDone),
    .rspData(rspData), .misalignFault(misalignFault), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // Behavioural RAM, one-cycle read latency, lane i = bits 8i+7:8i
  logic [31:0] ram [NWORDS];
  logic [7:0]  shadow [NBYTES];

  always @(posedge clk) begin
    if (memEn) begin
      memRdata <= ram[memAddr];
      for (int i = 0; i < 4; i++)
        if (memWe[i]) ram[memAddr][8*i +: 8] <= memWdata[8*i +: 8];
    end
  end

  int checks = 0;
  int errors = 0;
  int memCnt = 0;
  int doneCnt = 0;
  logic [AW-3:0] recAddr [2];
  logic [3:0]    recWe [2];

  always @(negedge clk) begin
    if (memEn) begin
      if (memCnt < 2) begin
        recAddr[memCnt] = memAddr;
        recWe[memCnt]   = memWe;
      end
      memCnt++;
    end
    if (reqDone) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nOf(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input int a, input int sz);
    logic [31:0] v = '0;
    for (int i = 0; i < nOf(sz); i++) v = (v << 8) | 32'(shadow[(a + i) % NBYTES]);
    return v;
  endfunction

  task automatic doAccess(input bit wr, input int sz, input int a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output bit flt, output int lat);
    @(negedge clk);
    memCnt   = 0;
    reqValid = 1'b1;
    reqWrite = wr;
    reqSize  = sz[1:0];
    reqAddr  = a[AW-1:0];
    reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!reqDone && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd  = rspData;
    flt = misalignFault;
    if (lat >= 20) chk(1'b0, "timeout", 32'(lat), 32'd3);
    if (wr && !flt)
      for (int i = 0; i < nOf(sz); i++)
        shadow[(a + i) % NBYTES] = 8'(wd >> (8 * (nOf(sz) - 1 - i)));
  endtask

  task automatic readCheck(input string req, input int sz, input int a,
                           input int expLat, input int expMem);
    logic [31:0] rd; bit flt; int lat;
    doAccess(1'b0, sz, a, 32'h0, rd, flt, lat);
    chk(rd == expRead(a, sz), req, rd, expRead(a, sz));
    chk(lat == expLat, {req, " latency"}, 32'(lat), 32'(expLat));
    chk(memCnt == expMem, {req, " mem cycles"}, 32'(memCnt), 32'(expMem));
  endtask

  task automatic t_reset;
    chk({reqBusy, reqDone, misalignFault, memEn} == 4'b0, "R1 flags in reset",
        {28'b0, reqBusy, reqDone, misalignFault, memEn}, 32'h0);
    chk(memWe == 4'b0, "R1 memWe in reset", {28'b0, memWe}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({reqBusy, reqDone, memEn} == 3'b0, "R1 idle after reset",
        {29'b0, reqBusy, reqDone, memEn}, 32'h0);
  endtask

  task automatic t_alignedRead;
    readCheck("R2 R4 byte@0", 0, 0, 2, 1);
    chk(expRead(0, 0) == 32'h01, "R4 byte@0 model", expRead(0, 0), 32'h01);
    readCheck("R2 byte@3", 0, 3, 2, 1);
    readCheck("R2 half@2", 1, 2, 2, 1);
    readCheck("R2 R4 word@4", 2, 4, 2, 1);
  endtask

  task automatic t_crossRead;
    logic [31:0] rd; bit flt; int lat;
    doAccess(1'b0, 2, 1, 32'h0, rd, flt, lat);
    chk(rd == 32'h02030405, "R3 word@1 merge", rd, 32'h02030405);
    chk(lat == 3 && memCnt == 2, "R3 word@1 timing", 32'(lat * 16 + memCnt), 32'h32);
    chk(recAddr[0] == 0 && recAddr[1] == 1, "R3 word order",
        {22'b0, recAddr[0], recAddr[1]}, 32'h1);
    readCheck("R3 word@7", 2, 7, 3, 2);
    readCheck("R3 word@0x46", 2, 'h46, 3, 2);
  endtask

  task automatic t_boundary;
    readCheck("R9 half@1 no split", 1, 1, 2, 1);
    readCheck("R9 byte@7 no split", 0, 7, 2, 1);
    readCheck("R9 half@3 split", 1, 3, 3, 2);
  endtask

  task automatic t_alignedWrite;
    logic [31:0] rd; bit flt; int lat;
    doAccess(1'b1, 1, 'h102, 32'h0000ABCD, rd, flt, lat);
    chk(memCnt == 1, "R5 one write cycle", 32'(memCnt), 32'd1);
    chk(recWe[0] == 4'b0011, "R5 R4 half lanes", {28'b0, recWe[0]}, 32'h3);
    doAccess(1'b1, 0, 'h108, 32'h0000005A, rd, flt, lat);
    chk(recWe[0] == 4'b1000, "R5 R4 byte lane 0", {28'b0, recWe[0]}, 32'h8);
    readCheck("R5 readback 0x100", 2, 'h100, 2, 1);
    readCheck("R5 readback 0x108", 2, 'h108, 2, 1);
  endtask

  task automatic t_crossWrite;
    logic [31:0] rd; bit flt; int lat;
    doAccess(1'b1, 2, 'h203, 32'h11223344, rd, flt, lat);
    chk(memCnt == 2 && lat == 3, "R6 two write cycles", 32'(memCnt), 32'd2);
    chk(recWe[0] == 4'b0001 && recWe[1] == 4'b1110, "R6 split lanes",
        {24'b0, recWe[0], recWe[1]}, 32'h1E);
    chk(recAddr[1] == recAddr[0] + 1'b1, "R6 second word",
        {22'b0, recAddr[0], recAddr[1]}, 32'h0);
    readCheck("R6 readback 0x200", 2, 'h200, 2, 1);
    readCheck("R6 readback 0x204", 2, 'h204, 2, 1);
    readCheck("R6 readback 0x203", 2, 'h203, 3, 2);
    chk(expRead('h203, 2) == 32'h11223344, "R6 model", expRead('h203, 2), 32'h11223344);
  endtask

  task automatic t_trap;
    logic [31:0] rd; bit flt; int lat;
    trapMode = 1'b1;
    doAccess(1'b0, 2, 5, 32'h0, rd, flt, lat);
    chk(flt && lat == 1, "R8 fault timing", 32'(lat), 32'd1);
    chk(memCnt == 0, "R8 no mem cycle", 32'(memCnt), 32'd0);
    doAccess(1'b1, 2, 'h301, 32'hDEADBEEF, rd, flt, lat);
    chk(flt && memCnt == 0, "R8 store trapped", 32'(memCnt), 32'd0);
    readCheck("R8 aligned in trap mode", 2, 'h300, 2, 1);
    trapMode = 1'b0;
    readCheck("R8 store left memory", 2, 'h301, 3, 2);
  endtask

  task automatic t_busyIgnore;
    int d0;
    logic [31:0] rd;
    @(negedge clk);
    d0 = doneCnt;
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd2; reqAddr = AW'('h10);
    @(negedge clk);
    reqWrite = 1'b1; reqSize = 2'd0; reqAddr = AW'('h20); reqWdata = 32'hEE;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqDone == 1'b1, "R7 done due", {31'b0, reqDone}, 32'h1);
    rd = rspData;
    chk(rd == expRead('h10, 2), "R7 data", rd, expRead('h10, 2));
    repeat (4) @(negedge clk);
    chk(doneCnt - d0 == 1, "R7 one done pulse", 32'(doneCnt - d0), 32'd1);
    readCheck("R7 busy request ignored", 0, 'h20, 2, 1);
  endtask

  task automatic t_wrap;
    readCheck("R10 wrap word", 2, NBYTES - 2, 3, 2);
    chk(recAddr[1] == '0, "R10 second at word 0", {22'b0, recAddr[1]}, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < NWORDS; w++) begin
      for (int b = 0; b < 4; b++) shadow[4 * w + b] = 8'(4 * w + b + 1);
      ram[w] = {shadow[4 * w], shadow[4 * w + 1], shadow[4 * w + 2], shadow[4 * w + 3]};
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_alignedRead();
    t_crossRead();
    t_boundary();
    t_alignedWrite();
    t_crossWrite();
    t_trap();
    t_busyIgnore();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule